// File: doc/BRIEF.md
# Sticky Zero-One Flag Detector

This block watches a serial input that delivers one bit per clock. When a 0 is followed directly by a 1, it raises a flag output. The flag stays raised through any run of 1s. It drops only after two consecutive 0s. A downstream block can use the flag as a latched "pattern seen" indication, and the incoming data stream clears it without any extra control.

The machine keeps its state in two bits, and each bit is updated like a J/K storage element. A small control unit derives the set and clear strobes for each state bit from the current state and the serial input. A datapath unit applies those strobes, holds the state and forms the output. The output is Mealy: it rises in the same clock cycle in which the completing 1 is presented, and it does not wait for the next edge. The three legal state codes are idle = 00, seen-zero = 01 and flagged = 10, written as {bit1, bit0}. Code 11 is never used. If code 11 is ever reached, it is steered back to idle.

Top module: `seq_flag_detector`

## Requirements
- R1: While `rst` is high at a rising clock edge, the state goes to 00 (idle). After that edge, `z` is 0 whatever the value of `x`.
- R2: From idle (00), `x`=0 moves the state to 01 on the next edge, and `x`=1 keeps it at 00.
- R3: From seen-zero (01), `x`=0 keeps the state at 01, and `x`=1 moves it to 10 on the next edge.
- R4: From flagged (10), `x`=0 moves the state to 01, and `x`=1 keeps it at 10.
- R5: In state 01 with `x`=1, `z` is 1 in the same cycle, before the clock edge that enters state 10.
- R6: In state 10, `z` is 1 for either value of `x`. This includes the first 0 after the flag was set.
- R7: `z` is 0 in idle, and in state 01 while `x`=0. A second consecutive 0 after the flag was set therefore clears `z`.
- R8: The state output never shows code 11 after reset. If code 11 is present, the next edge returns the state to 00.
- R9: Over a random serial stream of more than 1000 bits, `z` and the state bits match a behavioural model cycle by cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| x | input | 1 | Serial data bit, one per clock |
| z | output | 1 | Sticky flag, Mealy output |
| stateBits | output | 2 | Current state code {bit1, bit0} |

## Verification
The bench builds the block with its default two-bit state width. That is the only width at which the three codes and the unused fourth code exist, so every legal transition and the output in every state-and-input pair can be reached from the serial input. Directed sequences cover the same-cycle rise of the flag, holding the flag through runs of 1s, and the two-zero clear. A seeded random stream of 1200 bits then exercises every transition many times against the model.

// File: rtl/seqflag_pkg.sv
package seqflag_pkg;
  localparam int STATE_W = 2;

  typedef logic [STATE_W-1:0] stateCode_t;

  localparam stateCode_t ST_IDLE  = 2'b00;
  localparam stateCode_t ST_SEEN0 = 2'b01;
  localparam stateCode_t ST_FLAG  = 2'b10;
  localparam stateCode_t ST_BAD   = 2'b11;

  // Strobes from control to datapath: per-bit set (J) and clear (K),
  // plus a recovery request for the unused code.
  typedef struct packed {
    logic [STATE_W-1:0] jSet;
    logic [STATE_W-1:0] kClr;
    logic               recover;
  } jkStrobe_t;
endpackage

// File: rtl/seqflag_ctrl.sv
module seqflag_ctrl
  import seqflag_pkg::*;
(
  input  logic       x,
  input  stateCode_t stateQ,
  output jkStrobe_t  strobes
);
  // Excitation equations for the two state bits.
  always_comb begin
    strobes.jSet[1] = x & stateQ[0];
    strobes.kClr[1] = ~x;
    strobes.jSet[0] = ~x;
    strobes.kClr[0] = x;
    strobes.recover = (stateQ == ST_BAD);
  end
endmodule

// File: rtl/seqflag_dp.sv
module seqflag_dp
  import seqflag_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       x,
  input  jkStrobe_t  strobes,
  output stateCode_t stateQ,
  output logic       z
);
  // One J/K-style storage bit per state bit.
  for (genvar b = 0; b < STATE_W; b++) begin : g_jkBit
    logic jkNext;
    always_comb jkNext = (strobes.jSet[b] & ~stateQ[b]) | (~strobes.kClr[b] & stateQ[b]);
    always_ff @(posedge clk) begin
      if (rst || strobes.recover) stateQ[b] <= 1'b0;
      else                        stateQ[b] <= jkNext;
    end
  end

  // Mealy output: flagged state, or completing 1 seen in seen-zero state.
  always_comb z = stateQ[1] | (x & stateQ[0]);
endmodule

// File: rtl/seq_flag_detector.sv
module seq_flag_detector
  import seqflag_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               x,
  output logic               z,
  output logic [STATE_W-1:0] stateBits
);
  jkStrobe_t  strobes;
  stateCode_t stateQ;

  seqflag_ctrl ctrl_i (
    .x       (x),
    .stateQ  (stateQ),
    .strobes (strobes)
  );

  seqflag_dp dp_i (
    .clk     (clk),
    .rst     (rst),
    .x       (x),
    .strobes (strobes),
    .stateQ  (stateQ),
    .z       (z)
  );

  assign stateBits = stateQ;
endmodule

// File: rtl/seq_flag_detector_chk.sv
module seq_flag_detector_chk (
  input logic       clk,
  input logic       rst,
  input logic       x,
  input logic       z,
  input logic [1:0] stateBits
);
  p_reset_idle_r1: assert property (@(posedge clk) rst |=> (stateBits == 2'b00));

  p_idle_step_r2: assert property (@(posedge clk) disable iff (rst)
    (stateBits == 2'b00) |=> (stateBits == ($past(x) ? 2'b00 : 2'b01)));

  p_seen0_step_r3: assert property (@(posedge clk) disable iff (rst)
    (stateBits == 2'b01) |=> (stateBits == ($past(x) ? 2'b10 : 2'b01)));

  p_flag_step_r4: assert property (@(posedge clk) disable iff (rst)
    (stateBits == 2'b10) |=> (stateBits == ($past(x) ? 2'b10 : 2'b01)));

  p_mealy_rise_r5: assert property (@(posedge clk) disable iff (rst)
    ((stateBits == 2'b01) && x) |-> z);

  p_flag_held_r6: assert property (@(posedge clk) disable iff (rst)
    (stateBits == 2'b10) |-> z);

  p_flag_clear_r7: assert property (@(posedge clk) disable iff (rst)
    ((stateBits == 2'b00) || ((stateBits == 2'b01) && !x)) |-> !z);

  p_bad_recover_r8: assert property (@(posedge clk) disable iff (rst)
    (stateBits == 2'b11) |=> (stateBits == 2'b00));
endmodule

bind seq_flag_detector seq_flag_detector_chk chk_i (.*);

// File: tb/seq_flag_detector_tb.sv
`timescale 1ns/1ps
module seq_flag_detector_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       x   = 1'b0;
  logic       z;
  logic [1:0] stateBits;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic [1:0] refState = 2'b00;

  always #2.5 clk = ~clk;

  seq_flag_detector dut_i (
    .clk       (clk),
    .rst       (rst),
    .x         (x),
    .z         (z),
    .stateBits (stateBits)
  );

  function automatic logic [1:0] refNext(input logic [1:0] s, input logic b);
    case (s)
      2'b00:   return b ? 2'b00 : 2'b01;
      2'b01:   return b ? 2'b10 : 2'b01;
      2'b10:   return b ? 2'b10 : 2'b01;
      default: return 2'b00;
    endcase
  endfunction

  function automatic logic refFlag(input logic [1:0] s, input logic b);
    return (s == 2'b10) || ((s == 2'b01) && b);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic string zTag(input logic [1:0] s, input logic b);
    if (s == 2'b10) return "R6";
    if (s == 2'b01 && b) return "R5";
    return "R7";
  endfunction

  function automatic string sTag(input logic [1:0] s);
    if (s == 2'b00) return "R2";
    if (s == 2'b01) return "R3";
    return "R4";
  endfunction

  // Drive one bit; check z before the edge and the state after it.
  task automatic step(input logic b, input bit randomPhase);
    logic [1:0] expNext;
    @(negedge clk);
    x = b;
    #1;
    check(z === refFlag(refState, b), randomPhase ? "R9 z" : zTag(refState, b),
          int'(z), int'(refFlag(refState, b)));
    expNext = refNext(refState, b);
    @(posedge clk);
    #1;
    check(stateBits === expNext, randomPhase ? "R9 state" : sTag(refState),
          int'(stateBits), int'(expNext));
    check(stateBits !== 2'b11, "R8 code 11 seen", int'(stateBits), 0);
    refState = expNext;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    r = $urandom(32'h5EED1234);
    rst = 1'b1;
    x   = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check(stateBits === 2'b00, "R1 reset state", int'(stateBits), 0);
    check(z === 1'b0, "R1 reset z with x=1", int'(z), 0);
    @(negedge clk);
    rst = 1'b0;
    refState = 2'b00;

    // Directed: idle hold, 0-1 rise, hold on 1s, first 0 keeps flag, second 0 clears.
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    step(1'b1, 1'b0);

    // Reset in the middle of a flagged run.
    @(negedge clk);
    rst = 1'b1;
    x   = 1'b1;
    @(posedge clk);
    #1;
    check(stateBits === 2'b00, "R1 mid-run reset", int'(stateBits), 0);
    check(z === 1'b0, "R1 z after mid-run reset", int'(z), 0);
    @(negedge clk);
    rst = 1'b0;
    refState = 2'b00;

    // Random stream.
    for (int i = 0; i < 1200; i++) begin
      r = $urandom();
      step(r[0], 1'b1);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule